// File: doc/BRIEF.md
# Keyed forwarding table with command engine

This block holds a small fully associative forwarding table. Each entry pairs a key with a set of destination properties. The key is a 12-bit VLAN ID plus a 48-bit MAC address, and the properties are a destination address, a 2-bit destination kind and a locked flag. Software drives the block through five 32-bit registers:

- a control word,
- two key words,
- a properties word,
- a scan-option word.

Software first loads a key and/or properties. It then writes a command code into the control word with its start bit set. The engine carries the command out over the table and drops the start bit when it has finished.

Most commands walk the table one entry per cycle. These are insert/refresh, remove, exact-match query, index scan and the ordered "next larger key" walk. Reads and writes by index take a single cycle, and bulk invalidation clears one entry per cycle. Calling "next larger key" repeatedly, starting from an all-zero key, visits every entry in ascending (VLAN, MAC) order. This works because each hit copies the found key back into the key words.

Top module: `mac_fwd_table`

## Requirements
- R1: Writing register 0 with bit 0 set starts the command held in bits 3:1. Register 0 reads back with the busy flag in bit 0, the command in bits 3:1 and the entry index in bits 8 and up. The busy flag stays 1 for a fixed number of cycles after the write edge: N+1 for commands 0, 1, 2, 5 and 6; 1 for commands 3 and 4; N for command 7. Writing register 0 with bit 0 clear only updates the command and index fields and starts nothing.
- R2: Every register write is ignored while the busy flag is 1, including the write on the cycle in which the command finishes.
- R3: Register 1 holds the VLAN ID in bits 27:16, MAC byte 0 in bits 15:8 and MAC byte 1 in bits 7:0, and bits 31:28 read 0. Register 2 holds MAC bytes 2 to 5, with byte 2 in bits 31:24 and byte 5 in bits 7:0.
- R4: Register 3 holds the destination address in bits 11:0 and the destination kind in bits 13:12. Kinds 0 to 3 mean port, CPU/internal, aggregation group and multicast index, and are stored verbatim. The valid flag is in bit 16 and the locked flag in bit 17. Register 4 has skip-locked in bit 0 and search-until-found in bit 1.
- R5: Command 0 (learn) refreshes the properties of a valid entry whose key matches, in place. If there is no match, it fills the lowest-index invalid slot. On success the valid flag reads 1.
- R6: Learn into a full table with no matching key changes no entry and clears the valid flag.
- R7: Command 1 (unlearn) invalidates the lowest-index matching entry. The valid flag reports whether a match existed.
- R8: Command 2 (lookup) copies the matching entry's properties into register 3 with the valid flag set. On a miss only the valid flag is cleared.
- R9: Command 3 reads the entry at the index field into the key and property registers, including its valid flag, even for an invalid entry. Command 4 writes the key and property registers into that entry, and the entry's valid flag is taken from bit 16.
- R10: Command 6 returns the valid entry whose 60-bit key {VLAN, MAC byte 0..5} is the smallest one strictly greater than the loaded key. On a hit it loads that key and its properties with valid set. On a miss only the valid flag is cleared.
- R11: With skip-locked and until-found both set, command 6 passes over locked entries. With skip-locked set alone, a locked nearest entry yields a miss. With skip-locked clear, locked entries are returned.
- R12: Command 5 (scan) returns the lowest-index valid entry at or above the index field and writes its index back into the index field. On a miss only the valid flag is cleared.
- R13: Command 7 invalidates every entry and leaves the key and property registers untouched.
- R14: After reset all registers read 0 and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes (0 to 4) |
| wr_data | input | 32 | Register write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 32 | Register read data, combinational |

## Verification
A software register write and the end of a running command can land on the same clock edge. The engine's own result updates and a foreign write would then compete for the key and property registers. The bench provokes this by writing all-ones into key word 1 on chosen cycles of a command, including the exact edge on which the busy flag drops. After completion it requires the key registers to hold only the command's result. The behavioural model predicts the busy flag for every cycle, so a write that leaks through, or a completion that arrives one edge early or late, shows up as a mismatch on that cycle.

// File: rtl/mac_fwd_table.sv
module mac_fwd_table #(
  parameter int N      = 16,
  parameter int ADDR_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_sel,
  output logic [31:0] rd_data
);
  localparam int IDXW = $clog2(N);
  localparam int KW   = 60;
  localparam logic [IDXW-1:0] LAST = IDXW'(N - 1);

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_FIN, S_CLR} st_t;
  st_t st;

  logic            busy;
  logic [2:0]      cmd_q;
  logic [IDXW-1:0] idx_q, ptr;
  logic [11:0]     vid_q;
  logic [47:0]     mac_q;
  logic [ADDR_W-1:0] p_addr;
  logic [1:0]      p_type;
  logic            p_vld, p_lck, skip_lck, until_fnd;

  logic [KW-1:0]     t_key  [N];
  logic [ADDR_W-1:0] t_addr [N];
  logic [1:0]        t_type [N];
  logic              t_lck  [N];
  logic [N-1:0]      vld;

  logic            hit, fre, bst;
  logic [IDXW-1:0] hit_i, fre_i, bst_i;
  logic [KW-1:0]   bst_key;

  logic [KW-1:0] key_in, cur;
  assign key_in = {vid_q, mac_q};
  assign cur    = t_key[ptr];

  logic acc, start, is_eq, fn_q, sc_q, cand, fn_ok;
  assign acc   = wr_en && !busy;
  assign start = acc && wr_sel == 3'd0 && wr_data[0];
  assign is_eq = vld[ptr] && cur == key_in;
  assign fn_q  = vld[ptr] && cur > key_in && !(skip_lck && until_fnd && t_lck[ptr])
                 && (!bst || cur < bst_key);
  assign sc_q  = vld[ptr] && ptr >= idx_q && !bst;
  assign cand  = (cmd_q == 3'd5) ? sc_q : fn_q;
  assign fn_ok = bst && !(cmd_q == 3'd6 && skip_lck && !until_fnd && t_lck[bst_i]);

  logic            tw_en;
  logic [IDXW-1:0] tw_i;
  always_comb begin
    tw_en = 1'b0;
    tw_i  = idx_q;
    if (st == S_FIN) begin
      if (cmd_q == 3'd0 && hit) begin tw_en = 1'b1; tw_i = hit_i; end
      else if (cmd_q == 3'd0 && fre) begin tw_en = 1'b1; tw_i = fre_i; end
      else if (cmd_q == 3'd4) tw_en = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (tw_en) begin
      t_key[tw_i]  <= key_in;
      t_addr[tw_i] <= p_addr;
      t_type[tw_i] <= p_type;
      t_lck[tw_i]  <= p_lck;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; busy <= 1'b0; cmd_q <= '0; idx_q <= '0; ptr <= '0;
      vid_q <= '0; mac_q <= '0; p_addr <= '0; p_type <= '0; p_vld <= 1'b0;
      p_lck <= 1'b0; skip_lck <= 1'b0; until_fnd <= 1'b0; vld <= '0;
      hit <= 1'b0; fre <= 1'b0; bst <= 1'b0;
      hit_i <= '0; fre_i <= '0; bst_i <= '0; bst_key <= '0;
    end else begin
      if (acc) begin
        case (wr_sel)
          3'd0: begin cmd_q <= wr_data[3:1]; idx_q <= wr_data[8 +: IDXW]; end
          3'd1: begin vid_q <= wr_data[27:16]; mac_q[47:32] <= wr_data[15:0]; end
          3'd2: mac_q[31:0] <= wr_data;
          3'd3: begin
            p_addr <= wr_data[ADDR_W-1:0]; p_type <= wr_data[13:12];
            p_vld  <= wr_data[16];         p_lck  <= wr_data[17];
          end
          3'd4: begin skip_lck <= wr_data[0]; until_fnd <= wr_data[1]; end
          default: ;
        endcase
      end
      if (start) begin
        busy <= 1'b1; ptr <= '0;
        hit <= 1'b0; fre <= 1'b0; bst <= 1'b0;
        case (wr_data[3:1])
          3'd3, 3'd4: st <= S_FIN;
          3'd7:       st <= S_CLR;
          default:    st <= S_WALK;
        endcase
      end
      case (st)
        S_WALK: begin
          if (is_eq && !hit) begin hit <= 1'b1; hit_i <= ptr; end
          if (!vld[ptr] && !fre) begin fre <= 1'b1; fre_i <= ptr; end
          if (cand) begin bst <= 1'b1; bst_i <= ptr; bst_key <= cur; end
          ptr <= ptr + 1'b1;
          if (ptr == LAST) st <= S_FIN;
        end
        S_CLR: begin
          vld[ptr] <= 1'b0;
          ptr <= ptr + 1'b1;
          if (ptr == LAST) begin st <= S_IDLE; busy <= 1'b0; end
        end
        S_FIN: begin
          st <= S_IDLE; busy <= 1'b0;
          case (cmd_q)
            3'd0: begin
              if (hit || fre) vld[tw_i] <= 1'b1;
              p_vld <= hit || fre;
            end
            3'd1: begin
              if (hit) vld[hit_i] <= 1'b0;
              p_vld <= hit;
            end
            3'd2: begin
              if (hit) begin
                p_addr <= t_addr[hit_i]; p_type <= t_type[hit_i]; p_lck <= t_lck[hit_i];
              end
              p_vld <= hit;
            end
            3'd3: begin
              vid_q <= t_key[idx_q][59:48]; mac_q <= t_key[idx_q][47:0];
              p_addr <= t_addr[idx_q]; p_type <= t_type[idx_q];
              p_lck <= t_lck[idx_q]; p_vld <= vld[idx_q];
            end
            3'd4: vld[idx_q] <= p_vld;
            3'd5, 3'd6: begin
              if (fn_ok) begin
                vid_q <= bst_key[59:48]; mac_q <= bst_key[47:0];
                p_addr <= t_addr[bst_i]; p_type <= t_type[bst_i]; p_lck <= t_lck[bst_i];
                if (cmd_q == 3'd5) idx_q <= bst_i;
              end
              p_vld <= fn_ok;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  logic [31:0] prop_w;
  always_comb begin
    prop_w = '0;
    prop_w[ADDR_W-1:0] = p_addr;
    prop_w[13:12] = p_type;
    prop_w[16] = p_vld;
    prop_w[17] = p_lck;
  end

  always_comb begin
    case (rd_sel)
      3'd0:    rd_data = 32'({idx_q, 4'b0000, cmd_q, busy});
      3'd1:    rd_data = {4'b0000, vid_q, mac_q[47:32]};
      3'd2:    rd_data = mac_q[31:0];
      3'd3:    rd_data = prop_w;
      3'd4:    rd_data = {30'd0, until_fnd, skip_lck};
      default: rd_data = '0;
    endcase
  end

  logic unused_wr;
  assign unused_wr = ^wr_data;
endmodule

module mac_fwd_table_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic [2:0]   cmd_q,
  input logic [N-1:0] vld,
  input logic         wr_en,
  input logic [2:0]   wr_sel
);
  localparam int CW = $clog2(N + 3) + 1;
  logic [CW-1:0] bcnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else        bcnt <= busy ? bcnt + 1'b1 : '0;

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= CW'(N + 1)); // R1
  AST_CTRL_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en && wr_sel == 3'd0 |=> cmd_q == $past(cmd_q)); // R2
  AST_LEARN_ADDS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && cmd_q == 3'd0 |-> $countones(vld) <= $countones($past(vld)) + 1); // R5
  AST_UNLEARN_NEVER_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && cmd_q == 3'd1 |-> $countones(vld) <= $countones($past(vld))); // R7
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && cmd_q == 3'd7 |-> vld == '0); // R13
endmodule

bind mac_fwd_table mac_fwd_table_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_q(cmd_q),
  .vld(vld), .wr_en(wr_en), .wr_sel(wr_sel)
);

// File: tb/tb_mac_fwd_table.sv
module tb_mac_fwd_table;
  localparam int N = 16;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_sel = '0, rd_sel = '0;
  logic [31:0] wr_data = '0, rd_data;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  mac_fwd_table #(.N(N), .ADDR_W(12)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data));

  logic [59:0] mk [N];
  logic [11:0] ma [N];
  logic [1:0]  mt [N];
  logic        ml [N];
  logic        mv [N];
  logic [11:0] e_vid = '0;
  logic [47:0] e_mac = '0;
  logic [11:0] e_addr = '0;
  logic [1:0]  e_type = '0;
  logic        e_pv = 0, e_pl = 0, e_skip = 0, e_until = 0;
  logic [2:0]  e_cmd = '0;
  logic [3:0]  e_idx = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_exp(input int s);
    case (s)
      0: return 32'({e_idx, 4'b0000, e_cmd, 1'b0});
      1: return {4'b0, e_vid, e_mac[47:32]};
      2: return e_mac[31:0];
      3: return {14'd0, e_pl, e_pv, 2'b00, e_type, e_addr};
      default: return {30'd0, e_until, e_skip};
    endcase
  endfunction

  task automatic check_all(input string req);
    for (int s = 0; s < 5; s++) begin
      rd_sel = 3'(s); #1;
      chk(req, rd_data, rd_exp(s));
    end
    rd_sel = 3'd0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    case (s)
      3'd0: begin e_cmd = d[3:1]; e_idx = d[11:8]; end
      3'd1: begin e_vid = d[27:16]; e_mac[47:32] = d[15:0]; end
      3'd2: e_mac[31:0] = d;
      3'd3: begin e_addr = d[11:0]; e_type = d[13:12]; e_pv = d[16]; e_pl = d[17]; end
      3'd4: begin e_skip = d[0]; e_until = d[1]; end
      default: ;
    endcase
  endtask

  task automatic set_key(input logic [11:0] v, input logic [47:0] m);
    wr(3'd1, {4'b0, v, m[47:32]});
    wr(3'd2, m[31:0]);
  endtask

  task automatic set_props(input logic [11:0] a, input logic [1:0] t, input logic v, input logic l);
    wr(3'd3, {14'd0, l, v, 2'b00, t, a});
  endtask

  task automatic model_exec();
    logic [59:0] k;
    int h, f, b;
    k = {e_vid, e_mac};
    h = -1; f = -1; b = -1;
    for (int i = 0; i < N; i++) begin
      if (h < 0 && mv[i] && mk[i] == k) h = i;
      if (f < 0 && !mv[i]) f = i;
    end
    case (e_cmd)
      3'd0: begin
        if (h < 0) h = f;
        if (h >= 0) begin
          mk[h] = k; ma[h] = e_addr; mt[h] = e_type; ml[h] = e_pl; mv[h] = 1;
        end
        e_pv = (h >= 0);
      end
      3'd1: begin if (h >= 0) mv[h] = 0; e_pv = (h >= 0); end
      3'd2: begin
        if (h >= 0) begin e_addr = ma[h]; e_type = mt[h]; e_pl = ml[h]; end
        e_pv = (h >= 0);
      end
      3'd3: begin
        {e_vid, e_mac} = mk[e_idx]; e_addr = ma[e_idx]; e_type = mt[e_idx];
        e_pl = ml[e_idx]; e_pv = mv[e_idx];
      end
      3'd4: begin
        mk[e_idx] = k; ma[e_idx] = e_addr; mt[e_idx] = e_type; ml[e_idx] = e_pl; mv[e_idx] = e_pv;
      end
      3'd5, 3'd6: begin
        for (int i = 0; i < N; i++) begin
          if (e_cmd == 3'd5) begin
            if (b < 0 && mv[i] && i >= int'(e_idx)) b = i;
          end else if (mv[i] && mk[i] > k && !(e_skip && e_until && ml[i])) begin
            if (b < 0 || mk[i] < mk[b]) b = i;
          end
        end
        if (b >= 0 && e_cmd == 3'd6 && e_skip && !e_until && ml[b]) b = -1;
        if (b >= 0) begin
          {e_vid, e_mac} = mk[b]; e_addr = ma[b]; e_type = mt[b]; e_pl = ml[b];
          if (e_cmd == 3'd5) e_idx = 4'(b);
        end
        e_pv = (b >= 0);
      end
      default: for (int i = 0; i < N; i++) mv[i] = 0;
    endcase
  endtask

  task automatic run(input logic [2:0] c, input logic [3:0] ix, input int intrude, input string req);
    int lat;
    @(negedge clk); wr_en = 1'b1; wr_sel = 3'd0; wr_data = {20'd0, ix, 4'b0000, c, 1'b1};
    e_cmd = c; e_idx = ix;
    model_exec();
    lat = (c == 3'd3 || c == 3'd4) ? 1 : (c == 3'd7) ? N : N + 1;
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      rd_sel = 3'd0; #1;
      chk("R1 busy", 32'(rd_data[0]), 32'd1);
      if (k == intrude) begin wr_en = 1'b1; wr_sel = 3'd1; wr_data = 32'hFFFF_FFFF; end
      else wr_en = 1'b0;
    end
    @(negedge clk); wr_en = 1'b0;
    rd_sel = 3'd0; #1;
    chk("R1 done", 32'(rd_data[0]), 32'd0);
    check_all(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 0; mk[i] = '0; ma[i] = '0; mt[i] = '0; ml[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R14 reset");

    // R3 R4 R5: learn several keys in a mixed order
    set_key(12'd5, 48'h00_11_22_33_44_55); set_props(12'd7, 2'd0, 1, 0);
    run(3'd0, 4'd0, 0, "R5 learn A");
    set_key(12'd5, 48'h00_01_02_03_04_05); set_props(12'd2, 2'd1, 1, 0);
    run(3'd0, 4'd0, 0, "R5 learn B");
    set_key(12'd3, 48'hFF_EE_DD_CC_BB_AA); set_props(12'd4, 2'd2, 1, 0);
    run(3'd0, 4'd0, 0, "R5 learn C");
    set_key(12'd5, 48'hF0_00_00_00_00_01); set_props(12'hABC, 2'd3, 1, 1);
    run(3'd0, 4'd0, 0, "R4 learn D locked");
    set_key(12'd9, 48'h00_00_00_00_00_01); set_props(12'd1, 2'd0, 1, 0);
    run(3'd0, 4'd0, N + 1, "R2 learn E, write on final edge");

    // R8 lookup hit and miss
    set_key(12'd5, 48'h00_11_22_33_44_55); set_props(12'd0, 2'd0, 0, 0);
    run(3'd2, 4'd0, 3, "R8 lookup hit, R2 write mid-walk");
    set_key(12'd6, 48'h00_11_22_33_44_55); set_props(12'h55, 2'd1, 1, 1);
    run(3'd2, 4'd0, 0, "R8 lookup miss");

    // R5 refresh in place, then read it back
    set_key(12'd5, 48'h00_11_22_33_44_55); set_props(12'd9, 2'd1, 1, 0);
    run(3'd0, 4'd0, 0, "R5 refresh");
    run(3'd3, 4'd0, 1, "R9 read idx0, R2 intrude");
    chk("R5 refreshed addr", 32'(e_addr), 32'd9);

    // R10 ordered walk from zero key
    wr(3'd4, 32'd0);
    set_key(12'd0, 48'd0);
    for (int n = 0; n < 6; n++) run(3'd6, 4'd0, 0, "R10 walk");
    chk("R10 walk ends in miss", 32'(e_pv), 32'd0);

    // R11 locked handling after A
    set_key(12'd5, 48'h00_11_22_33_44_55);
    wr(3'd4, 32'd3);
    run(3'd6, 4'd0, 0, "R11 skip+until");
    chk("R11 skipped to E", 32'(e_vid), 32'd9);
    set_key(12'd5, 48'h00_11_22_33_44_55);
    wr(3'd4, 32'd1);
    run(3'd6, 4'd0, 0, "R11 skip only miss");
    set_key(12'd5, 48'h00_11_22_33_44_55);
    wr(3'd4, 32'd0);
    run(3'd6, 4'd0, 0, "R11 no skip returns locked");

    // R12 scan from index 2
    run(3'd5, 4'd2, 0, "R12 scan");
    run(3'd5, 4'd6, 0, "R12 scan miss");

    // R9 write/read by index
    set_key(12'hFFF, 48'h12_34_56_78_9A_BC); set_props(12'h3C3, 2'd3, 1, 1);
    run(3'd4, 4'd10, 0, "R9 write idx10");
    set_key(12'd0, 48'd0); set_props(12'd0, 2'd0, 0, 0);
    run(3'd3, 4'd10, 0, "R9 read idx10");

    // R7 unlearn hit and miss
    set_key(12'd5, 48'h00_01_02_03_04_05);
    run(3'd1, 4'd0, 0, "R7 unlearn hit");
    run(3'd1, 4'd0, 0, "R7 unlearn miss");

    // R1: control write without start does not start
    wr(3'd0, 32'h0000_0306);
    rd_sel = 3'd0; #1;
    chk("R1 no start", rd_data, 32'h0000_0306);

    // R6 fill table then overflow
    set_props(12'd8, 2'd0, 1, 0);
    for (int n = 0; n < 14; n++) begin
      set_key(12'd100, 48'(n));
      run(3'd0, 4'd0, 0, "R6 fill");
    end
    chk("R6 full learn rejected", 32'(e_pv), 32'd0);

    // R13 clear all
    run(3'd7, 4'd0, 0, "R13 clear");
    run(3'd3, 4'd12, 0, "R13 R9 read invalid entry");
    chk("R13 entry invalid", 32'(e_pv), 32'd0);
    set_key(12'd5, 48'h00_11_22_33_44_55);
    run(3'd2, 4'd0, 0, "R13 lookup after clear");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule